// File: doc/BRIEF.md
# Cross-Domain DMA Halfword Buffer with Stalling Diagnostic Port

This block is a small shared store of eight 16-bit halfwords that sits between two bus subsystems with unrelated clocks. A DMA engine on the host-clock side (the "local" side) and a DMA engine on the other clock (the "remote" side) take turns owning the store. One side fills it, then hands it over, and the other side drains or refills it. Ownership passes as toggle events through two-flop synchronizers in each direction. The storage flops sit in the host clock domain. Remote writes are staged in the remote domain and committed across the boundary with a toggle request and acknowledge, one halfword at a time.

A host processor on the local clock can also read or write the store through a slow port meant for diagnostics. Every host access stalls the host with a wait output while a request toggle makes a round trip through the remote clock domain. If a local DMA burst is active, the stall also lasts until that burst ends. Only then is the access performed. Host writes are not guarded by ownership. A host write made while data is parked between the two DMA turns replaces that data.

Top module: `xdbuf_top`

## Requirements
- R1: After reset every halfword of the store reads zero, `host_wait` is low, the local side owns the store (`lcl_own`=1) and the remote side does not (`rmt_own`=0).
- R2: Host address bits [3:1] select the halfword. A halfword access (`host_byte`=0) ignores bit 0. A byte access (`host_byte`=1) uses bit 0 to pick the lane: 0 selects bits [7:0] and 1 selects bits [15:8]. A byte write takes its data from `host_wdata[7:0]` and changes only that lane. A byte read returns the lane in `host_rdata[7:0]` with bits [15:8] zero.
- R3: A request is sampled on a clock edge where `host_wait` is low, and `host_wait` is high in the following cycle. Requests made while `host_wait` is high are ignored.
- R4: The stall covers a request/echo round trip through the remote clock domain, so `host_wait` stays high for at least 3 host clock cycles per access.
- R5: While `lcl_busy` is high, `host_wait` does not fall. Once the round trip has completed, `host_wait` falls one cycle after `lcl_busy` is sampled low.
- R6: A local write (`lcl_busy`, `lcl_we`) changes halfword `lcl_addr` when the local side owns the store. `lcl_rdata` shows halfword `lcl_addr` combinationally. A `lcl_done` pulse while the local side owns the store clears `lcl_own` in the next cycle.
- R7: Local writes made while the local side does not own the store are ignored.
- R8: After the local handoff, `rmt_own` rises. A remote write (`rmt_we`) while `rmt_own` is high and `rmt_wbusy` is low is staged, and `rmt_wbusy` is held until the write has been committed to the store. `rmt_rdata` shows halfword `rmt_addr` one remote clock later.
- R9: A `rmt_done` pulse, while the remote side owns the store with no write pending, clears `rmt_own` at the next remote edge, and `lcl_own` then returns high. Remote writes made without ownership are ignored.
- R10: A host write changes the store in any ownership state. DMA data parked between turns is overwritten, and the remote side reads the host data.
- R11: On a read, `host_rdata` is valid in the cycle in which `host_wait` falls, and it holds until the next access completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_h | input | 1 | Host / local DMA clock |
| rst_hn | input | 1 | Asynchronous active-low reset, host domain |
| clk_r | input | 1 | Remote DMA clock |
| rst_rn | input | 1 | Asynchronous active-low reset, remote domain |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_byte | input | 1 | 1 = byte access, 0 = halfword access |
| host_addr | input | 4 | Byte address inside the buffer window |
| host_wdata | input | 16 | Host write data |
| host_wait | output | 1 | Stall the host |
| host_rdata | output | 16 | Host read data |
| lcl_busy | input | 1 | Local DMA burst in progress |
| lcl_we | input | 1 | Local DMA write strobe |
| lcl_addr | input | 3 | Local DMA halfword index |
| lcl_wdata | input | 16 | Local DMA write data |
| lcl_done | input | 1 | Local DMA turn finished, hand over |
| lcl_rdata | output | 16 | Halfword at lcl_addr |
| lcl_own | output | 1 | Local side owns the store |
| rmt_we | input | 1 | Remote DMA write strobe |
| rmt_addr | input | 3 | Remote DMA halfword index |
| rmt_wdata | input | 16 | Remote DMA write data |
| rmt_done | input | 1 | Remote DMA turn finished, hand back |
| rmt_rdata | output | 16 | Halfword at rmt_addr, remote-clocked |
| rmt_own | output | 1 | Remote side owns the store |
| rmt_wbusy | output | 1 | Remote write still crossing |

## Verification
The assertions take for granted that `lcl_done` and `rmt_done` are only pulsed at the end of a turn, and that the local engine does not write outside a burst it has flagged with `lcl_busy`. The handoff checks also assume that the engines wait on `lcl_own`, `rmt_own` and `rmt_wbusy` instead of guessing synchronizer delays. The stimulus keeps to this. Random host traffic runs only while the local side owns an idle store. Remote activity waits on `rmt_own` and `rmt_wbusy`. Local writes are issued without ownership only in the one directed case that shows they are dropped.

// File: rtl/xdbuf_pkg.sv
package xdbuf_pkg;
    // Host access width selector
    typedef enum logic {
        ACC_HALF = 1'b0,
        ACC_BYTE = 1'b1
    } acc_size_e;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/xdbuf_sync.sv
module xdbuf_sync #(
    parameter int STAGES = 2,
    parameter int W      = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d = {stg_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/xdbuf_store.sv
module xdbuf_store #(
    parameter int DW     = 16,
    parameter int DEPTH  = 8,
    parameter int STAGES = 2,
    localparam int AW    = $clog2(DEPTH),
    localparam int LANES = DW / xdbuf_pkg::BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    // local DMA
    input  logic             l_busy,
    input  logic             l_we,
    input  logic [AW-1:0]    l_addr,
    input  logic [DW-1:0]    l_wdata,
    input  logic             l_done,
    output logic [DW-1:0]    l_rdata,
    output logic             l_own,
    // from remote domain (asynchronous)
    input  logic             rtog_a,
    input  logic             wtog_a,
    input  logic [AW-1:0]    hold_addr,
    input  logic [DW-1:0]    hold_data,
    output logic             wack,
    output logic             gtog,
    // host commit
    input  logic             hc_en,
    input  logic [AW-1:0]    hc_addr,
    input  logic [LANES-1:0] hc_be,
    input  logic [DW-1:0]    hc_data,
    input  logic [AW-1:0]    h_raddr,
    output logic [DW-1:0]    h_rdata,
    // remote read mux (registered on the remote side)
    input  logic [AW-1:0]    r_raddr,
    output logic [DW-1:0]    r_rdata_a
);
    localparam int BW = xdbuf_pkg::BYTE_W;

    typedef struct packed {
        logic gtog;
        logic wack;
    } ctl_t;

    ctl_t          ctl_d, ctl_q;
    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];
    logic [1:0]    syn_q;
    logic          rtog_s, wtog_s;

    xdbuf_sync #(.STAGES(STAGES), .W(2)) u_sync_r2h (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({rtog_a, wtog_a}),
        .q    (syn_q)
    );
    assign rtog_s = syn_q[1];
    assign wtog_s = syn_q[0];

    assign l_own = (rtog_s == ctl_q.gtog);

    always_comb begin
        ctl_d = ctl_q;
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        // remote write arriving across the boundary
        if (wtog_s != ctl_q.wack) begin
            mem_d[hold_addr] = hold_data;
            ctl_d.wack       = wtog_s;
        end
        // local DMA write, only with ownership inside a burst
        if (l_busy && l_we && l_own) mem_d[l_addr] = l_wdata;
        // host diagnostic write, unguarded, last word wins
        if (hc_en) begin
            for (int b = 0; b < LANES; b++) begin
                if (hc_be[b]) mem_d[hc_addr][b*BW +: BW] = hc_data[b*BW +: BW];
            end
        end
        if (l_done && l_own) ctl_d.gtog = ~ctl_q.gtog;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            ctl_q <= ctl_d;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign wack      = ctl_q.wack;
    assign gtog      = ctl_q.gtog;
    assign l_rdata   = mem_q[l_addr];
    assign h_rdata   = mem_q[h_raddr];
    assign r_rdata_a = mem_q[r_raddr];

    // R6: handing the turn over drops local ownership at once
    assert_local_handoff_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (l_done && l_own) |=> !l_own);
endmodule

// File: rtl/xdbuf_remote.sv
module xdbuf_remote #(
    parameter int DW     = 16,
    parameter int DEPTH  = 8,
    parameter int STAGES = 2,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          r_we,
    input  logic [AW-1:0] r_addr,
    input  logic [DW-1:0] r_wdata,
    input  logic          r_done,
    output logic [DW-1:0] r_rdata,
    output logic          r_own,
    output logic          r_wbusy,
    // from host domain (asynchronous)
    input  logic          gtog_a,
    input  logic          wack_a,
    input  logic          hreq_a,
    input  logic [DW-1:0] rd_a,
    // to host domain
    output logic          rtog,
    output logic          wtog,
    output logic [AW-1:0] hold_addr,
    output logic [DW-1:0] hold_data,
    output logic          hreq_echo
);
    typedef struct packed {
        logic          rtog;
        logic          wtog;
        logic [AW-1:0] hold_addr;
        logic [DW-1:0] hold_data;
        logic [DW-1:0] rdata;
    } rst_t;

    rst_t       st_d, st_q;
    logic [2:0] syn_q;
    logic       gtog_s, wack_s, accept;

    xdbuf_sync #(.STAGES(STAGES), .W(3)) u_sync_h2r (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({gtog_a, wack_a, hreq_a}),
        .q    (syn_q)
    );
    assign gtog_s    = syn_q[2];
    assign wack_s    = syn_q[1];
    assign hreq_echo = syn_q[0];

    assign r_own   = (gtog_s != st_q.rtog);
    assign r_wbusy = (st_q.wtog != wack_s);
    assign accept  = r_own && r_we && !r_wbusy;

    always_comb begin
        st_d       = st_q;
        st_d.rdata = rd_a;
        if (accept) begin
            st_d.hold_addr = r_addr;
            st_d.hold_data = r_wdata;
            st_d.wtog      = ~st_q.wtog;
        end
        if (r_own && r_done && !r_wbusy && !r_we) st_d.rtog = ~st_q.rtog;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign r_rdata   = st_q.rdata;
    assign rtog      = st_q.rtog;
    assign wtog      = st_q.wtog;
    assign hold_addr = st_q.hold_addr;
    assign hold_data = st_q.hold_data;

    // R8: staged write stays put while it crosses
    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        r_wbusy |=> ($stable(st_q.hold_data) && $stable(st_q.hold_addr)));
    // R9: handing back drops remote ownership at the next edge
    assert_remote_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_done && r_own && !r_wbusy && !r_we) |=> !r_own);
endmodule

// File: rtl/xdbuf_hostport.sv
module xdbuf_hostport #(
    parameter int DW     = 16,
    parameter int DEPTH  = 8,
    parameter int STAGES = 2,
    localparam int AW    = $clog2(DEPTH),
    localparam int LANES = DW / xdbuf_pkg::BYTE_W,
    localparam int LB    = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int HAW   = AW + LB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_req,
    input  logic             host_we,
    input  logic             host_byte,
    input  logic [HAW-1:0]   host_addr,
    input  logic [DW-1:0]    host_wdata,
    output logic             host_wait,
    output logic [DW-1:0]    host_rdata,
    input  logic             l_busy,
    output logic             hreq_tog,
    input  logic             echo_a,
    output logic             hc_en,
    output logic [AW-1:0]    hc_addr,
    output logic [LANES-1:0] hc_be,
    output logic [DW-1:0]    hc_data,
    output logic [AW-1:0]    h_raddr,
    input  logic [DW-1:0]    h_rdata
);
    import xdbuf_pkg::*;
    localparam int BW = BYTE_W;

    typedef struct packed {
        logic           busy;
        logic           tog;
        logic           we;
        acc_size_e      size;
        logic [HAW-1:0] addr;
        logic [DW-1:0]  wdata;
        logic [DW-1:0]  rdata;
    } hst_t;

    hst_t          st_d, st_q;
    logic          echo_s, commit;
    logic [LB-1:0] lane;
    logic [DW-1:0] shifted;

    xdbuf_sync #(.STAGES(STAGES), .W(1)) u_sync_echo (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (echo_a),
        .q    (echo_s)
    );

    assign lane    = st_q.addr[LB-1:0];
    assign commit  = st_q.busy && (echo_s == st_q.tog) && !l_busy;
    assign shifted = h_rdata >> {lane, 3'b000};

    always_comb begin
        st_d  = st_q;
        hc_be = '0;
        if (st_q.size == ACC_BYTE) hc_be[lane] = 1'b1;
        else                       hc_be = '1;
        hc_data = (st_q.size == ACC_BYTE) ? {LANES{st_q.wdata[BW-1:0]}} : st_q.wdata;
        if (!st_q.busy && host_req) begin
            st_d.busy  = 1'b1;
            st_d.tog   = ~st_q.tog;
            st_d.we    = host_we;
            st_d.size  = host_byte ? ACC_BYTE : ACC_HALF;
            st_d.addr  = host_addr;
            st_d.wdata = host_wdata;
        end else if (commit) begin
            st_d.busy = 1'b0;
            if (!st_q.we) begin
                if (st_q.size == ACC_BYTE) begin
                    st_d.rdata         = '0;
                    st_d.rdata[BW-1:0] = shifted[BW-1:0];
                end else begin
                    st_d.rdata = h_rdata;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign host_wait  = st_q.busy;
    assign host_rdata = st_q.rdata;
    assign hreq_tog   = st_q.tog;
    assign hc_en      = commit && st_q.we;
    assign hc_addr    = st_q.addr[HAW-1:LB];
    assign h_raddr    = st_q.addr[HAW-1:LB];

    // R3: stall starts the cycle after the request is taken
    assert_wait_rises_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !host_wait) |=> host_wait);
    // R3: a request during a stall does not replace the captured one
    assert_req_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wait && host_req) |=> ($stable(st_q.addr) && $stable(st_q.wdata)));
    // R5: local burst keeps the host stalled
    assert_busy_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wait && l_busy) |=> host_wait);
    // R11: read data holds between accesses
    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_wait && !host_req) |=> $stable(host_rdata));
endmodule

// File: rtl/xdbuf_top.sv
module xdbuf_top #(
    parameter int DW     = 16,
    parameter int DEPTH  = 8,
    parameter int STAGES = 2,
    localparam int AW    = $clog2(DEPTH),
    localparam int LANES = DW / xdbuf_pkg::BYTE_W,
    localparam int LB    = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int HAW   = AW + LB
) (
    input  logic           clk_h,
    input  logic           rst_hn,
    input  logic           clk_r,
    input  logic           rst_rn,
    input  logic           host_req,
    input  logic           host_we,
    input  logic           host_byte,
    input  logic [HAW-1:0] host_addr,
    input  logic [DW-1:0]  host_wdata,
    output logic           host_wait,
    output logic [DW-1:0]  host_rdata,
    input  logic           lcl_busy,
    input  logic           lcl_we,
    input  logic [AW-1:0]  lcl_addr,
    input  logic [DW-1:0]  lcl_wdata,
    input  logic           lcl_done,
    output logic [DW-1:0]  lcl_rdata,
    output logic           lcl_own,
    input  logic           rmt_we,
    input  logic [AW-1:0]  rmt_addr,
    input  logic [DW-1:0]  rmt_wdata,
    input  logic           rmt_done,
    output logic [DW-1:0]  rmt_rdata,
    output logic           rmt_own,
    output logic           rmt_wbusy
);
    logic             rtog, wtog, wack, gtog, hreq_tog, hreq_echo, hc_en;
    logic [AW-1:0]    hold_addr, hc_addr, h_raddr;
    logic [DW-1:0]    hold_data, hc_data, h_rdata, r_rdata_a;
    logic [LANES-1:0] hc_be;

    xdbuf_hostport #(.DW(DW), .DEPTH(DEPTH), .STAGES(STAGES)) u_host (
        .clk       (clk_h),
        .rst_n     (rst_hn),
        .host_req  (host_req),
        .host_we   (host_we),
        .host_byte (host_byte),
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .host_wait (host_wait),
        .host_rdata(host_rdata),
        .l_busy    (lcl_busy),
        .hreq_tog  (hreq_tog),
        .echo_a    (hreq_echo),
        .hc_en     (hc_en),
        .hc_addr   (hc_addr),
        .hc_be     (hc_be),
        .hc_data   (hc_data),
        .h_raddr   (h_raddr),
        .h_rdata   (h_rdata)
    );

    xdbuf_store #(.DW(DW), .DEPTH(DEPTH), .STAGES(STAGES)) u_store (
        .clk      (clk_h),
        .rst_n    (rst_hn),
        .l_busy   (lcl_busy),
        .l_we     (lcl_we),
        .l_addr   (lcl_addr),
        .l_wdata  (lcl_wdata),
        .l_done   (lcl_done),
        .l_rdata  (lcl_rdata),
        .l_own    (lcl_own),
        .rtog_a   (rtog),
        .wtog_a   (wtog),
        .hold_addr(hold_addr),
        .hold_data(hold_data),
        .wack     (wack),
        .gtog     (gtog),
        .hc_en    (hc_en),
        .hc_addr  (hc_addr),
        .hc_be    (hc_be),
        .hc_data  (hc_data),
        .h_raddr  (h_raddr),
        .h_rdata  (h_rdata),
        .r_raddr  (rmt_addr),
        .r_rdata_a(r_rdata_a)
    );

    xdbuf_remote #(.DW(DW), .DEPTH(DEPTH), .STAGES(STAGES)) u_remote (
        .clk      (clk_r),
        .rst_n    (rst_rn),
        .r_we     (rmt_we),
        .r_addr   (rmt_addr),
        .r_wdata  (rmt_wdata),
        .r_done   (rmt_done),
        .r_rdata  (rmt_rdata),
        .r_own    (rmt_own),
        .r_wbusy  (rmt_wbusy),
        .gtog_a   (gtog),
        .wack_a   (wack),
        .hreq_a   (hreq_tog),
        .rd_a     (r_rdata_a),
        .rtog     (rtog),
        .wtog     (wtog),
        .hold_addr(hold_addr),
        .hold_data(hold_data),
        .hreq_echo(hreq_echo)
    );
endmodule

// File: tb/xdbuf_top_tb.sv
module xdbuf_top_tb;
    logic clk_h = 0, clk_r = 0, rst_hn = 0, rst_rn = 0;
    logic host_req = 0, host_we = 0, host_byte = 0;
    logic [3:0] host_addr = 0;
    logic [15:0] host_wdata = 0;
    logic host_wait;
    logic [15:0] host_rdata;
    logic lcl_busy = 0, lcl_we = 0, lcl_done = 0;
    logic [2:0] lcl_addr = 0;
    logic [15:0] lcl_wdata = 0, lcl_rdata;
    logic lcl_own;
    logic rmt_we = 0, rmt_done = 0;
    logic [2:0] rmt_addr = 0;
    logic [15:0] rmt_wdata = 0, rmt_rdata;
    logic rmt_own, rmt_wbusy;

    int tests = 0, fails = 0;
    bit finished = 0;
    logic [15:0] bm [8];

    always #2   clk_h = ~clk_h;   // 250 MHz
    always #3.5 clk_r = ~clk_r;

    xdbuf_top u_dut (.*);

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(bit byt, logic [3:0] a);
        logic [15:0] w = bm[a[3:1]];
        if (!byt) return w;
        return a[0] ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
    endfunction

    function automatic void model_wr(bit byt, logic [3:0] a, logic [15:0] d);
        if (!byt) bm[a[3:1]] = d;
        else if (a[0]) bm[a[3:1]][15:8] = d[7:0];
        else bm[a[3:1]][7:0] = d[7:0];
    endfunction

    // host access; inj=1 adds a stray write request during the stall
    task automatic hacc(bit we, bit byt, logic [3:0] a, logic [15:0] wd, bit inj,
                        output logic [15:0] rd, output int cyc);
        @(negedge clk_h);
        host_req = 1; host_we = we; host_byte = byt; host_addr = a; host_wdata = wd;
        @(negedge clk_h);
        chk("R3 wait after request", {15'd0, host_wait}, 16'd1);
        if (inj) begin host_we = 1; host_byte = 0; host_addr = 4'hA; host_wdata = 16'hDEAD; end
        else host_req = 0;
        cyc = 1;
        if (inj) begin @(negedge clk_h); host_req = 0; cyc++; end
        while (host_wait && cyc < 2000) begin @(negedge clk_h); if (host_wait) cyc++; end
        rd = host_rdata;
        if (we) model_wr(byt, a, wd);
    endtask

    task automatic lread(logic [2:0] a, string tag);
        @(negedge clk_h); lcl_addr = a; #0.5;
        chk(tag, lcl_rdata, bm[a]);
    endtask

    task automatic rread(logic [2:0] a, logic [15:0] exp, string tag);
        @(negedge clk_r); rmt_addr = a;
        repeat (2) @(negedge clk_r);
        chk(tag, rmt_rdata, exp);
    endtask

    task automatic rwrite(logic [2:0] a, logic [15:0] d);
        @(negedge clk_r); rmt_we = 1; rmt_addr = a; rmt_wdata = d;
        @(negedge clk_r); rmt_we = 0;
        for (int k = 0; k < 100 && rmt_wbusy; k++) @(negedge clk_r);
    endtask

    initial begin
        logic [15:0] rd;
        int cyc;
        for (int i = 0; i < 8; i++) bm[i] = 16'h0;
        repeat (3) @(negedge clk_h);
        rst_hn = 1; rst_rn = 1;
        @(negedge clk_h);
        // R1 reset state
        chk("R1 wait low", {15'd0, host_wait}, 16'd0);
        chk("R1 local owns", {15'd0, lcl_own}, 16'd1);
        chk("R1 remote not owner", {15'd0, rmt_own}, 16'd0);
        for (int i = 0; i < 8; i++) lread(i[2:0], "R1 zero after reset");

        // R2 halfword and byte lanes
        hacc(1, 0, 4'hD, 16'hA55A, 0, rd, cyc);     // bit0 ignored -> hw6
        hacc(0, 0, 4'hC, 16'h0, 0, rd, cyc);
        chk("R2 halfword read", rd, 16'hA55A);
        chk("R4 min stall", {15'd0, (cyc >= 3)}, 16'd1);
        hacc(1, 1, 4'hD, 16'hFF3C, 0, rd, cyc);     // upper lane only
        hacc(0, 0, 4'hC, 16'h0, 0, rd, cyc);
        chk("R2 byte write one lane", rd, 16'h3C5A);
        hacc(0, 1, 4'hD, 16'h0, 0, rd, cyc);
        chk("R2 byte read upper zero-ext", rd, 16'h003C);
        hacc(0, 1, 4'hC, 16'h0, 0, rd, cyc);
        chk("R2 byte read lower", rd, 16'h005A);
        // R11 hold
        repeat (5) @(negedge clk_h);
        chk("R11 rdata held", host_rdata, 16'h005A);

        // R3 stray request ignored
        hacc(0, 0, 4'h2, 16'h0, 1, rd, cyc);
        chk("R3 read ok under stray req", rd, bm[1]);
        lread(3'd5, "R3 stray write dropped");

        // R5 local burst stall
        @(negedge clk_h); lcl_busy = 1;
        @(negedge clk_h); host_req = 1; host_we = 0; host_byte = 0; host_addr = 4'hC;
        @(negedge clk_h); host_req = 0;
        repeat (40) @(negedge clk_h);
        chk("R5 wait held while busy", {15'd0, host_wait}, 16'd1);
        lcl_busy = 0;
        @(negedge clk_h);
        chk("R5 released one cycle after busy", {15'd0, host_wait}, 16'd0);
        chk("R11 rdata valid on release", host_rdata, bm[6]);

        // random host traffic
        for (int n = 0; n < 120; n++) begin
            bit we = $urandom_range(0, 1);
            bit byt = $urandom_range(0, 1);
            logic [3:0] a = 4'($urandom_range(0, 15));
            logic [15:0] d = 16'($urandom);
            logic [15:0] e = exp_read(byt, a);
            hacc(we, byt, a, d, 0, rd, cyc);
            if (!we) chk("R2/R11 random read", rd, e);
        end

        // R6 local burst
        @(negedge clk_h); lcl_busy = 1;
        for (int i = 0; i < 4; i++) begin
            lcl_we = 1; lcl_addr = i[2:0]; lcl_wdata = 16'h1100 + 16'(i);
            bm[i] = 16'h1100 + 16'(i);
            @(negedge clk_h);
        end
        lcl_we = 0; lcl_busy = 0;
        for (int i = 0; i < 4; i++) lread(i[2:0], "R6 local write");
        @(negedge clk_h); lcl_done = 1;
        @(negedge clk_h); lcl_done = 0;
        chk("R6 handoff clears own", {15'd0, lcl_own}, 16'd0);
        for (int k = 0; k < 50 && !rmt_own; k++) @(negedge clk_r);
        chk("R8 remote owns", {15'd0, rmt_own}, 16'd1);

        // R7 local write without ownership
        @(negedge clk_h); lcl_busy = 1; lcl_we = 1; lcl_addr = 3'd3; lcl_wdata = 16'hBAD0;
        @(negedge clk_h); lcl_busy = 0; lcl_we = 0;
        lread(3'd3, "R7 write without ownership dropped");

        // R10 host overwrites parked data; R8 remote write
        rwrite(3'd4, 16'h4444); bm[4] = 16'h4444;
        rread(3'd4, 16'h4444, "R8 remote write readback");
        hacc(1, 0, 4'h8, 16'hB0B0, 0, rd, cyc);
        rread(3'd4, 16'hB0B0, "R10 host overwrites remote data");
        hacc(1, 1, 4'h5, 16'h00EE, 0, rd, cyc);
        rread(3'd2, bm[2], "R10 host overwrites local DMA data");
        chk("R10 merged lane", bm[2], 16'hEE02);
        rwrite(3'd7, 16'h7777); bm[7] = 16'h7777;

        // R9 return
        @(negedge clk_r); rmt_done = 1;
        @(negedge clk_r); rmt_done = 0;
        chk("R9 remote own cleared", {15'd0, rmt_own}, 16'd0);
        for (int k = 0; k < 50 && !lcl_own; k++) @(negedge clk_h);
        chk("R9 local own back", {15'd0, lcl_own}, 16'd1);
        lread(3'd7, "R8 remote data visible locally");
        @(negedge clk_r); rmt_we = 1; rmt_addr = 3'd7; rmt_wdata = 16'hBEEF;
        @(negedge clk_r); rmt_we = 0;
        chk("R9 no write staged without ownership", {15'd0, rmt_wbusy}, 16'd0);
        repeat (10) @(negedge clk_h);
        lread(3'd7, "R9 remote write dropped");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_h);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule